// File: doc/BRIEF.md
# Two-Set Integer ALU with Registered Condition Code

This block is the arithmetic and logic stage of a small 32-bit processor core. One strobe (`exec_en`) hands it an operation: a 4-bit code plus a set-select bit. With the set-select bit low, the code picks a two-operand operation on `opnd_a` and `opnd_b`. With it high, the code picks a one-operand operation on `opnd_a`. The carry-in comes from the block's own four-bit condition code. Operand fetch, immediate extraction and register writeback are handled elsewhere.

The block registers its outputs, so an operation issued in one cycle appears on the ports after the next rising edge:

- `res_q` holds the last value the block wrote.
- `dst_we` pulses high for one cycle when that value must go to the destination register.
- `flags_q` holds the condition code.

Some operations change only some of these. Copy writes the destination but leaves the flags alone. Compare, bit test and compare-with-zero set the flags but do not write. The four top codes of each set leave everything unchanged.

Top module: `alu32_cc`

## Requirements
- R1: While `rst_n` is low, and until the first operation after reset, `res_q`, `flags_q` and `dst_we` are all zero.
- R2: Nothing changes in a cycle where `exec_en` is low. `res_q` and `flags_q` hold, and `dst_we` is low in the cycle that follows. Results appear one edge after the issuing cycle.
- R3: Two-operand add (0000), add with carry (0001), subtract (0010) and subtract with borrow (0011) write the 32-bit result.
  - C is the carry out for the adds and the borrow for the subtracts.
  - The with-carry and with-borrow forms add or subtract the current C.
  - V is signed overflow.
- R4: These operations write the result, set Z and N from the result, and clear C and V:
  - two-operand AND (0100), OR (0101) and XOR (0110);
  - one-operand NOT (0010), byte swap (1000, byte order reversed), sign-extend from 16 bits (1010) and sign-extend from 8 bits (1011).
- R5: Two-operand copy (0111) writes `opnd_b` and leaves all four flags unchanged.
- R6: Two-operand compare (1000) sets the flags exactly as subtract would. Bit test (1001) sets them exactly as AND would. Neither asserts `dst_we`, and `res_q` holds.
- R7: Two-operand 1010 and 1011 multiply the low 16 bits of both operands, unsigned and signed respectively, into a 32-bit product. Z and N follow the product, and C and V are cleared.
- R8: One-operand increment (0000), decrement (0001) and negate (0111, computed as 0 minus A) set C and V as an add of 1, a subtract of 1 and a subtract from zero would.
- R9: One-operand shifts each move by one bit and put the bit shifted out into C:
  - logical left (0011);
  - logical right (0100);
  - arithmetic left (0101), which sets V when bit 31 of the result differs from bit 31 of the operand;
  - arithmetic right (0110), which keeps bit 31.

  The other shifts clear V.
- R10: One-operand compare-with-zero (1001) sets Z and N from `opnd_a`, clears C and V, and does not write.
- R11: Codes 1100 to 1111 in either set change neither `res_q` nor `flags_q` and do not assert `dst_we`.
- R12: `op_mono` = 0 selects the two-operand set and `op_mono` = 1 the one-operand set. `flags_q` carries V in bit 3, C in bit 2, Z in bit 1 and N in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Issue strobe for the operation on the other inputs |
| op_mono | input | 1 | Set select: 0 two-operand, 1 one-operand |
| op_sel | input | 4 | Operation code within the selected set |
| opnd_a | input | 32 | First operand, and the sole operand of one-operand codes |
| opnd_b | input | 32 | Second operand |
| res_q | output | 32 | Registered result |
| dst_we | output | 1 | One-cycle destination write strobe |
| flags_q | output | 4 | Registered condition code {V, C, Z, N} |

## Verification
The hardest conditions to reach from the ports are those that depend on the flag register itself. The carry-consuming subtract and add must run with C both set and clear. The flag-preserving paths (copy, compare-class and unused codes) must run with a non-zero condition code standing, so that a wrongful update is visible. Random operations are therefore issued back to back, with no reset between them, and operands are drawn heavily from 0, all-ones, the most negative value and the most positive value. The previous operation's carry and overflow thus feed the next one in many combinations. Directed sequences first set particular flags, then issue copy, compare and unused codes and check that the flags survive.

// File: rtl/alu32_cc_pkg.sv
package alu32_cc_pkg;

  typedef struct packed {
    logic v;
    logic c;
    logic z;
    logic n;
  } alu_flags_t;

  typedef enum logic [3:0] {
    DY_ADD  = 4'h0,
    DY_ADC  = 4'h1,
    DY_SUB  = 4'h2,
    DY_SBB  = 4'h3,
    DY_AND  = 4'h4,
    DY_OR   = 4'h5,
    DY_XOR  = 4'h6,
    DY_COPY = 4'h7,
    DY_CMP  = 4'h8,
    DY_TST  = 4'h9,
    DY_MULU = 4'hA,
    DY_MULS = 4'hB
  } dy_op_e;

  typedef enum logic [3:0] {
    MO_INC  = 4'h0,
    MO_DEC  = 4'h1,
    MO_NOT  = 4'h2,
    MO_LSL  = 4'h3,
    MO_LSR  = 4'h4,
    MO_ASL  = 4'h5,
    MO_ASR  = 4'h6,
    MO_NEG  = 4'h7,
    MO_BSWP = 4'h8,
    MO_CMPZ = 4'h9,
    MO_SXW  = 4'hA,
    MO_SXB  = 4'hB
  } mo_op_e;

endpackage

// File: rtl/alu_addsub.sv
// Shared carry-chain: sum = x + y + cin. Callers pre-invert y to subtract.
module alu_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opx,
  input  logic [DW-1:0] opy,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  logic [DW:0] wide;

  always_comb begin
    wide = {1'b0, opx} + {1'b0, opy} + {{DW{1'b0}}, cin};
    sum  = wide[DW-1:0];
    cout = wide[DW];
    ovf  = (opx[DW-1] == opy[DW-1]) && (wide[DW-1] != opx[DW-1]);
  end
endmodule

// File: rtl/alu_mul_half.sv
// Half-width multiply, signed or unsigned, full-width product.
module alu_mul_half #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] mx,
  input  logic [DW-1:0] my,
  input  logic          sgn,
  output logic [DW-1:0] prod
);
  localparam int HW = DW / 2;

  logic signed [HW:0]     ex_x;
  logic signed [HW:0]     ex_y;
  logic signed [2*HW+1:0] full;

  always_comb begin
    ex_x = {sgn & mx[HW-1], mx[HW-1:0]};
    ex_y = {sgn & my[HW-1], my[HW-1:0]};
    full = ex_x * ex_y;
    prod = full[DW-1:0];
  end
endmodule

// File: rtl/alu_dyadic.sv
module alu_dyadic
  import alu32_cc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    code,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output alu_flags_t    fl,
  output logic          upd,
  output logic          wr
);
  logic [DW-1:0] add_y;
  logic          add_ci;
  logic [DW-1:0] add_s;
  logic          add_co;
  logic          add_v;
  logic [DW-1:0] prod;
  logic          is_sub;

  alu_addsub #(.DW(DW)) u_add (
    .opx (a),
    .opy (add_y),
    .cin (add_ci),
    .sum (add_s),
    .cout(add_co),
    .ovf (add_v)
  );

  alu_mul_half #(.DW(DW)) u_mul (
    .mx  (a),
    .my  (b),
    .sgn (code == DY_MULS),
    .prod(prod)
  );

  always_comb begin
    is_sub = (code == DY_SUB) || (code == DY_SBB) || (code == DY_CMP);
    add_y  = is_sub ? ~b : b;
    unique case (code)
      DY_ADC:          add_ci = c_in;
      DY_SUB, DY_CMP:  add_ci = 1'b1;
      DY_SBB:          add_ci = ~c_in;
      default:         add_ci = 1'b0;
    endcase
  end

  always_comb begin
    res  = '0;
    fl   = '0;
    upd  = 1'b1;
    wr   = 1'b1;
    case (code)
      DY_ADD, DY_ADC, DY_SUB, DY_SBB, DY_CMP: begin
        res  = add_s;
        fl.c = is_sub ? ~add_co : add_co;
        fl.v = add_v;
        wr   = (code != DY_CMP);
      end
      DY_AND, DY_TST: begin
        res = a & b;
        wr  = (code != DY_TST);
      end
      DY_OR:            res = a | b;
      DY_XOR:           res = a ^ b;
      DY_COPY: begin
        res = b;
        upd = 1'b0;
      end
      DY_MULU, DY_MULS: res = prod;
      default: begin
        upd = 1'b0;
        wr  = 1'b0;
      end
    endcase
    fl.z = (res == '0);
    fl.n = res[DW-1];
  end
endmodule

// File: rtl/alu_monadic.sv
module alu_monadic
  import alu32_cc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [3:0]    code,
  output logic [DW-1:0] res,
  output alu_flags_t    fl,
  output logic          upd,
  output logic          wr
);
  localparam int NBYTE = DW / 8;
  localparam int HW    = DW / 2;

  logic [DW-1:0] add_x;
  logic [DW-1:0] add_y;
  logic [DW-1:0] add_s;
  logic          add_co;
  logic          add_v;
  logic [DW-1:0] swapped;

  for (genvar gi = 0; gi < NBYTE; gi++) begin : g_swap
    assign swapped[8*gi +: 8] = a[8*(NBYTE-1-gi) +: 8];
  end

  // inc: a+0+1, dec: a+~1+1, neg: 0+~a+1
  always_comb begin
    unique case (code)
      MO_DEC: begin
        add_x = a;
        add_y = ~{{(DW-1){1'b0}}, 1'b1};
      end
      MO_NEG: begin
        add_x = '0;
        add_y = ~a;
      end
      default: begin
        add_x = a;
        add_y = '0;
      end
    endcase
  end

  alu_addsub #(.DW(DW)) u_add (
    .opx (add_x),
    .opy (add_y),
    .cin (1'b1),
    .sum (add_s),
    .cout(add_co),
    .ovf (add_v)
  );

  always_comb begin
    res = '0;
    fl  = '0;
    upd = 1'b1;
    wr  = 1'b1;
    case (code)
      MO_INC: begin
        res  = add_s;
        fl.c = add_co;
        fl.v = add_v;
      end
      MO_DEC, MO_NEG: begin
        res  = add_s;
        fl.c = ~add_co;
        fl.v = add_v;
      end
      MO_NOT:  res = ~a;
      MO_LSL: begin
        res  = {a[DW-2:0], 1'b0};
        fl.c = a[DW-1];
      end
      MO_LSR: begin
        res  = {1'b0, a[DW-1:1]};
        fl.c = a[0];
      end
      MO_ASL: begin
        res  = {a[DW-2:0], 1'b0};
        fl.c = a[DW-1];
        fl.v = a[DW-1] ^ a[DW-2];
      end
      MO_ASR: begin
        res  = {a[DW-1], a[DW-1:1]};
        fl.c = a[0];
      end
      MO_BSWP: res = swapped;
      MO_CMPZ: begin
        res = a;
        wr  = 1'b0;
      end
      MO_SXW:  res = {{HW{a[HW-1]}}, a[HW-1:0]};
      MO_SXB:  res = {{(DW-8){a[7]}}, a[7:0]};
      default: begin
        upd = 1'b0;
        wr  = 1'b0;
      end
    endcase
    fl.z = (res == '0);
    fl.n = res[DW-1];
  end
endmodule

// File: rtl/alu32_cc.sv
module alu32_cc
  import alu32_cc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic          op_mono,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] res_q,
  output logic          dst_we,
  output logic [3:0]    flags_q
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC_STAGES-1];

  alu_flags_t    fl_cur;
  logic [DW-1:0] dy_res, mo_res, sel_res;
  alu_flags_t    dy_fl, mo_fl, sel_fl;
  logic          dy_upd, mo_upd, sel_upd;
  logic          dy_wr, mo_wr, sel_wr;

  assign fl_cur = alu_flags_t'(flags_q);

  alu_dyadic #(.DW(DW)) u_dy (
    .a   (opnd_a),
    .b   (opnd_b),
    .code(op_sel),
    .c_in(fl_cur.c),
    .res (dy_res),
    .fl  (dy_fl),
    .upd (dy_upd),
    .wr  (dy_wr)
  );

  alu_monadic #(.DW(DW)) u_mo (
    .a   (opnd_a),
    .code(op_sel),
    .res (mo_res),
    .fl  (mo_fl),
    .upd (mo_upd),
    .wr  (mo_wr)
  );

  always_comb begin
    sel_res = op_mono ? mo_res : dy_res;
    sel_fl  = op_mono ? mo_fl  : dy_fl;
    sel_upd = op_mono ? mo_upd : dy_upd;
    sel_wr  = op_mono ? mo_wr  : dy_wr;
  end

  logic [DW-1:0] res_d;
  logic [3:0]    flags_d;
  logic          we_d;
  logic          res_en;
  logic          flags_en;

  always_comb begin
    res_en   = exec_en && sel_wr;
    flags_en = exec_en && sel_upd;
    res_d    = res_en   ? sel_res : res_q;
    flags_d  = flags_en ? 4'(sel_fl) : flags_q;
    we_d     = res_en;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_q   <= '0;
      flags_q <= '0;
      dst_we  <= 1'b0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
      dst_we  <= we_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !exec_en |=> (!dst_we && $stable(res_q) && $stable(flags_q))); // R2

  AST_COPY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (exec_en && !op_mono && op_sel == DY_COPY) |=> (dst_we && $stable(flags_q))); // R5

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (exec_en && ((!op_mono && (op_sel == DY_CMP || op_sel == DY_TST)) ||
                 (op_mono && op_sel == MO_CMPZ)))
    |=> (!dst_we && $stable(res_q))); // R6

  AST_UNUSED_INERT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (exec_en && op_sel[3:2] == 2'b11)
    |=> (!dst_we && $stable(res_q) && $stable(flags_q))); // R11

  AST_ZN_TRACK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (exec_en && sel_wr && sel_upd)
    |=> (flags_q[1] == (res_q == '0) && flags_q[0] == res_q[DW-1])); // R4
endmodule

// File: tb/test_alu32_cc.sv
module test_alu32_cc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en;
  logic        op_mono;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] res_q;
  logic        dst_we;
  logic [3:0]  flags_q;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_res;
  logic [3:0]  exp_fl;

  always #2.5 clk = ~clk;

  alu32_cc i_alu32_cc (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_mono(op_mono),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_q(res_q), .dst_we(dst_we), .flags_q(flags_q)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic m, input logic [3:0] c);
    if (c[3:2] == 2'b11) return "R11";
    if (!m) begin
      case (c)
        4'h0, 4'h1, 4'h2, 4'h3: return "R3";
        4'h7:                   return "R5";
        4'h8, 4'h9:             return "R6";
        4'hA, 4'hB:             return "R7";
        default:                return "R4";
      endcase
    end
    case (c)
      4'h0, 4'h1, 4'h7:       return "R8";
      4'h3, 4'h4, 4'h5, 4'h6: return "R9";
      4'h9:                   return "R10";
      default:                return "R4";
    endcase
  endfunction

  // returns {upd, wr, res[31:0], flags{V,C,Z,N}}
  function automatic logic [37:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                         input logic [3:0] c, input logic m,
                                         input logic [3:0] f);
    logic [32:0] t;
    logic [31:0] r;
    logic cf, vf, upd, wr;
    logic [3:0] nf;
    r = '0; cf = 0; vf = 0; upd = 1; wr = 1; t = '0;
    if (!m) begin
      case (c)
        4'h0, 4'h1: begin
          t = {1'b0, a} + {1'b0, b} + ((c == 4'h1) ? {32'd0, f[2]} : 33'd0);
          r = t[31:0]; cf = t[32];
          vf = (a[31] == b[31]) && (r[31] != a[31]);
        end
        4'h2, 4'h3, 4'h8: begin
          t = {1'b0, a} - {1'b0, b} - ((c == 4'h3) ? {32'd0, f[2]} : 33'd0);
          r = t[31:0]; cf = t[32];
          vf = (a[31] != b[31]) && (r[31] != a[31]);
          wr = (c != 4'h8);
        end
        4'h4, 4'h9: begin r = a & b; wr = (c != 4'h9); end
        4'h5: r = a | b;
        4'h6: r = a ^ b;
        4'h7: begin r = b; upd = 0; end
        4'hA: r = {16'd0, a[15:0]} * {16'd0, b[15:0]};
        4'hB: r = $signed({{16{a[15]}}, a[15:0]}) * $signed({{16{b[15]}}, b[15:0]});
        default: begin upd = 0; wr = 0; end
      endcase
    end else begin
      case (c)
        4'h0: begin r = a + 1; cf = (a == 32'hFFFF_FFFF); vf = (a == 32'h7FFF_FFFF); end
        4'h1: begin r = a - 1; cf = (a == 0); vf = (a == 32'h8000_0000); end
        4'h2: r = ~a;
        4'h3: begin r = a << 1; cf = a[31]; end
        4'h4: begin r = a >> 1; cf = a[0]; end
        4'h5: begin r = a << 1; cf = a[31]; vf = a[31] ^ a[30]; end
        4'h6: begin r = $signed(a) >>> 1; cf = a[0]; end
        4'h7: begin r = 0 - a; cf = (a != 0); vf = (a == 32'h8000_0000); end
        4'h8: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
        4'h9: begin r = a; wr = 0; end
        4'hA: r = {{16{a[15]}}, a[15:0]};
        4'hB: r = {{24{a[7]}}, a[7:0]};
        default: begin upd = 0; wr = 0; end
      endcase
    end
    nf = upd ? {vf, cf, (r == 0), r[31]} : f;
    return {upd, wr, r, nf};
  endfunction

  task automatic do_op(input logic m, input logic [3:0] c,
                       input logic [31:0] a, input logic [31:0] b);
    logic [37:0] e;
    string tg;
    e  = ref_op(a, b, c, m, exp_fl);
    tg = tag_of(m, c);
    @(negedge clk);
    exec_en = 1; op_mono = m; op_sel = c; opnd_a = a; opnd_b = b;
    @(negedge clk);
    exec_en = 0;
    if (e[36]) exp_res = e[35:4];
    exp_fl = e[3:0];
    chk(tg, "result", res_q, exp_res);
    chk(tg, "write", {31'd0, dst_we}, {31'd0, e[36]});
    chk(tg, "flags", {28'd0, flags_q}, {28'd0, exp_fl});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 7)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return {16'd0, 16'($urandom)};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #200_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; exec_en = 0; op_mono = 0; op_sel = 0; opnd_a = 0; opnd_b = 0;
    exp_res = 0; exp_fl = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset result", res_q, 0);
    chk("R1", "reset flags", {28'd0, flags_q}, 0);
    chk("R1", "reset write", {31'd0, dst_we}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "post-reset result", res_q, 0);

    // R12 flag bit order: 0x7FFFFFFF+1 -> V and N only = 4'b1001
    do_op(0, 4'h0, 32'h7FFF_FFFF, 32'h1);
    chk("R12", "V/N position", {28'd0, flags_q}, 32'h9);
    // R3 carry and zero: all-ones + 1 -> C,Z = 4'b0110
    do_op(0, 4'h0, 32'hFFFF_FFFF, 32'h1);
    chk("R3", "carry-out flags", {28'd0, flags_q}, 32'h6);
    // R3 add-with-carry consumes standing C
    do_op(0, 4'h1, 32'h10, 32'h20);
    chk("R3", "adc sum", res_q, 32'h31);
    // R3 borrow then subtract-with-borrow
    do_op(0, 4'h2, 32'h1, 32'h2);
    do_op(0, 4'h3, 32'h10, 32'h1);
    chk("R3", "sbb result", res_q, 32'hE);
    // R5 copy with flags standing
    do_op(0, 4'h2, 32'h0, 32'h1);
    do_op(0, 4'h7, 32'h0, 32'h0);
    chk("R5", "copy keeps flags", {28'd0, flags_q}, 32'h5);
    // R6 compare keeps result
    do_op(0, 4'h8, 32'h5, 32'h5);
    chk("R6", "compare leaves result", res_q, 32'h0);
    // R7 signed multiply -1 * -1 ignoring upper halves
    do_op(0, 4'hB, 32'hABCD_FFFF, 32'h1234_FFFF);
    chk("R7", "signed product", res_q, 32'h1);
    // R10 compare with zero on negative
    do_op(1, 4'h9, 32'h8000_0000, 32'h0);
    // R11 unused with flags standing, both sets
    do_op(1, 4'hE, 32'h1234_5678, 32'h0);
    do_op(0, 4'hC, 32'h1234_5678, 32'h9);
    // R2 idle: inputs change, exec low
    @(negedge clk);
    op_sel = 4'h0; opnd_a = 32'h55; opnd_b = 32'h66;
    @(negedge clk);
    chk("R2", "idle result", res_q, exp_res);
    chk("R2", "idle flags", {28'd0, flags_q}, {28'd0, exp_fl});
    chk("R2", "idle write", {31'd0, dst_we}, 0);

    for (int i = 0; i < 4000; i++) begin
      do_op(1'($urandom), 4'($urandom), pick(), pick());
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule